// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

This block collects 64 interrupt sources into two 32-bit banks and drives one interrupt request line to a single processor. Each bank keeps three software-visible bit sets: latched events, an enable mask and the sampled live levels. It also holds a per-bit trigger configuration that is fixed at reset and says which bits are edge-type and which are level-type.

An edge-type source that rises latches an event bit. That bit stays set until software writes a one to it through the bank's clear register. A level-type source never latches an event. It requests service for as long as its sampled level is high, and a clear write cannot remove it. Software reaches the banks through a simple 32-bit register port with byte addresses. The request output is registered, and reads return data one cycle later together with a valid strobe.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset the events, mask and levels registers of both banks read zero, `irq_out` is 0 and `rd_valid` is 0.
- R2: Bank 0 occupies byte addresses 0x10..0x1F and bank 1 occupies 0x20..0x2F. Within a bank, the low address nibble selects the register: 0x0 is events (read-only), 0x4 is mask (read/write), 0x8 is clear (write-only) and 0xC is levels (read-only).
- R3: An address whose bank index ((addr - 0x10) >> 4, taken modulo 4096) is 2 or more, or whose low nibble is not one of 0x0, 0x4, 0x8 or 0xC, reads as zero and has no effect when written. A write to the events or levels register has no effect either.
- R4: Input k maps to bank 1-(k>>5) at bit k&31. Inputs 0..31 therefore land in bank 1 and inputs 32..63 land in bank 0.
- R5: The levels register equals the mapped inputs as sampled at the previous clock edge.
- R6: When an edge-type input is sampled going from 0 to 1, its event bit is set, and it stays set after the input falls.
- R7: Level-type bits never set an event bit, and a clear write leaves a level-type request active while its input stays high.
- R8: A write to the clear register clears every edge-type event bit written as 1 and leaves the others unchanged.
- R9: When a clear write and a new rising edge hit the same bit in the same cycle, the event bit ends up set.
- R10: `irq_out` is 1 exactly when, in some bank, (events | (levels & level_type)) & mask is nonzero. It follows a change one clock edge after that change is sampled.
- R11: A mask write replaces the whole 32-bit mask of the bank it addresses.
- R12: A read strobe in one cycle gives `rd_valid` = 1 and the register contents in the next cycle. `rd_valid` is 0 after a cycle with no read strobe.
- R13: At reset the level-type configuration is 0x00000000 for bank 0 and 0x1FF00000 for bank 1 (bits 20..28 of bank 1 are level-type).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_ren | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after reg_ren |
| irq_in | input | 64 | Interrupt sources, numbered 0..63 |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that `irq_in` holds a defined value on every sampled edge. They also assume that `rst_n` is released synchronously, so the levels history they compare against starts from the reset value. The bench drives `irq_in` to zero from time zero and changes every input and strobe one time unit after a rising edge, well inside the cycle. It never raises read and write strobes to an undecoded address together with a source change, so each check has a single cause.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

  // Register selected by address bits [3:2] inside a bank window.
  typedef enum logic [1:0] {
    SEL_EVENTS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_LEVELS = 2'd3
  } reg_sel_e;

  localparam int unsigned WIN_SHIFT = 4;   // log2 of the bank window size in bytes
  localparam int unsigned WIN_BASE  = 16;  // byte address of the first bank window

endpackage

// File: rtl/dbi_decode.sv
module dbi_decode
  import dbi_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NBANKS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBANKS-1:0] bank_hit,
  output reg_sel_e          sel,
  output logic              sel_ok
);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] idx;
  logic              in_range;

  always_comb begin
    rel      = addr - ADDR_W'(WIN_BASE);
    idx      = rel >> WIN_SHIFT;
    in_range = (idx < ADDR_W'(NBANKS));
    sel      = reg_sel_e'(addr[3:2]);
    sel_ok   = (addr[1:0] == 2'b00);
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_hit
    assign bank_hit[b] = in_range && (idx == ADDR_W'(b));
  end

endmodule

// File: rtl/dbi_bank.sv
module dbi_bank #(
  parameter int unsigned   W       = 32,
  parameter logic [W-1:0]  LVL_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] events_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] levels_q,
  output logic         pend_next
);

  logic [W-1:0] events_n;
  logic [W-1:0] mask_n;
  logic [W-1:0] rise;
  logic [W-1:0] clr_bits;

  // Next-state logic
  always_comb begin
    rise     = src & ~levels_q & ~LVL_RST;
    clr_bits = clr_we ? (wdata & ~LVL_RST) : '0;
    events_n = (events_q & ~clr_bits) | rise;   // new edge wins over a clear
    mask_n   = wdata;
    pend_next = |((events_n | (src & LVL_RST)) & (mask_we ? mask_n : mask_q));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events_q <= '0;
      mask_q   <= '0;
      levels_q <= '0;
    end else begin
      events_q <= events_n;
      levels_q <= src;
      if (mask_we) begin
        mask_q <= mask_n;
      end
    end
  end

endmodule

// File: rtl/dbi_irq_out.sv
module dbi_irq_out #(
  parameter int unsigned NBANKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANKS-1:0] pend,
  output logic              irq_q
);

  logic irq_n;

  always_comb begin
    irq_n = |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import dbi_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned W      = 32,
  parameter int unsigned NBANKS = 2,
  parameter logic [NBANKS*W-1:0] LVL_CFG = 64'h1FF00000_00000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wen,
  input  logic [W-1:0]        reg_wdata,
  input  logic                reg_ren,
  output logic [W-1:0]        rd_data,
  output logic                rd_valid,
  input  logic [NBANKS*W-1:0] irq_in,
  output logic                irq_out
);

  localparam int unsigned NSRC = NBANKS * W;

  logic [NBANKS-1:0] bank_hit;
  reg_sel_e          sel;
  logic              sel_ok;
  logic [NBANKS-1:0] pend;

  logic [W-1:0] ev_q  [NBANKS];
  logic [W-1:0] msk_q [NBANKS];
  logic [W-1:0] lv_q  [NBANKS];

  // Flattened bank state, bank b at bits [b*W +: W]
  logic [NSRC-1:0] ev_all;
  logic [NSRC-1:0] mask_all;
  logic [NSRC-1:0] lv_all;

  logic [W-1:0] rd_data_n;
  logic         rd_valid_n;

  dbi_decode #(
    .ADDR_W (ADDR_W),
    .NBANKS (NBANKS)
  ) u_decode (
    .addr     (reg_addr),
    .bank_hit (bank_hit),
    .sel      (sel),
    .sel_ok   (sel_ok)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic mask_we;
    logic clr_we;

    assign mask_we = reg_wen && bank_hit[b] && sel_ok && (sel == SEL_MASK);
    assign clr_we  = reg_wen && bank_hit[b] && sel_ok && (sel == SEL_CLEAR);

    // Source numbering runs backwards across banks
    dbi_bank #(
      .W       (W),
      .LVL_RST (LVL_CFG[b*W +: W])
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (irq_in[(NBANKS-1-b)*W +: W]),
      .mask_we   (mask_we),
      .clr_we    (clr_we),
      .wdata     (reg_wdata),
      .events_q  (ev_q[b]),
      .mask_q    (msk_q[b]),
      .levels_q  (lv_q[b]),
      .pend_next (pend[b])
    );

    assign ev_all[b*W +: W]   = ev_q[b];
    assign mask_all[b*W +: W] = msk_q[b];
    assign lv_all[b*W +: W]   = lv_q[b];
  end

  dbi_irq_out #(
    .NBANKS (NBANKS)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .irq_q (irq_out)
  );

  // Read path: next state
  always_comb begin
    rd_data_n  = '0;
    rd_valid_n = reg_ren;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank_hit[b] && sel_ok) begin
        case (sel)
          SEL_EVENTS: rd_data_n = ev_q[b];
          SEL_MASK:   rd_data_n = msk_q[b];
          SEL_LEVELS: rd_data_n = lv_q[b];
          default:    rd_data_n = '0;
        endcase
      end
    end
  end

  // Read path: registers, data loads only on a read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_valid_n;
      if (reg_ren) begin
        rd_data <= rd_data_n;
      end
    end
  end

endmodule

// File: rtl/dbi_checker.sv
module dbi_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned W      = 32,
  parameter int unsigned NBANKS = 2,
  parameter logic [NBANKS*W-1:0] LVL_CFG = 64'h1FF00000_00000000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wen,
  input logic                reg_ren,
  input logic                rd_valid,
  input logic [NBANKS*W-1:0] irq_in,
  input logic                irq_out,
  input logic [NBANKS*W-1:0] ev_all,
  input logic [NBANKS*W-1:0] mask_all,
  input logic [NBANKS*W-1:0] lv_all
);

  localparam int unsigned LIMIT = 16 + NBANKS * 16;

  logic [NBANKS*W-1:0] mapped;
  logic [NBANKS*W-1:0] fresh_edge;
  logic                bad_addr;

  always_comb begin
    for (int b = 0; b < NBANKS; b++) begin
      mapped[b*W +: W] = irq_in[(NBANKS-1-b)*W +: W];
    end
    fresh_edge = mapped & ~lv_all & ~LVL_CFG;
    bad_addr   = (reg_addr < ADDR_W'(16)) || (reg_addr >= ADDR_W'(LIMIT));
  end

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ren |=> rd_valid);

  assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_ren |=> !rd_valid);

  assert_levels_mapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lv_all == $past(mapped)));

  assert_edge_latches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_all & $past(fresh_edge)) == $past(fresh_edge)));

  assert_level_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_all & LVL_CFG) == '0);

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == '0) |-> !irq_out);

  assert_bad_addr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && bad_addr) |=> (mask_all == $past(mask_all)));

endmodule

bind dual_bank_intc dbi_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wen  (reg_wen),
  .reg_ren  (reg_ren),
  .rd_valid (rd_valid),
  .irq_in   (irq_in),
  .irq_out  (irq_out),
  .ev_all   (ev_all),
  .mask_all (mask_all),
  .lv_all   (lv_all)
);

// File: tb/dual_bank_intc_test.sv
module dual_bank_intc_test;

  logic        clk;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_wen;
  logic [31:0] reg_wdata;
  logic        reg_ren;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [63:0] irq_in;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dual_bank_intc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_ren   (reg_ren),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wen   = 1'b1;
    tick();
    reg_wen   = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    reg_ren  = 1'b1;
    tick();
    reg_ren  = 1'b0;
    chk({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic set_in(input logic [63:0] v);
    irq_in = v;
    tick();
  endtask

  task automatic cleanup();
    set_in('0);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h028, 32'hFFFF_FFFF);
    wr(12'h014, 32'h0);
    wr(12'h024, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rd("R1 ev0", 12'h010, 32'h0);
    rd("R1 mask0", 12'h014, 32'h0);
    rd("R1 lv0", 12'h01C, 32'h0);
    rd("R1 ev1", 12'h020, 32'h0);
    rd("R1 mask1", 12'h024, 32'h0);
    rd("R1 lv1", 12'h02C, 32'h0);
    tick();
    chk("R12 rd_valid idle", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_mapping();
    set_in(64'h0000_0100_0000_0008);  // inputs 3 and 40
    rd("R4 R5 lv1", 12'h02C, 32'h0000_0008);
    rd("R4 R5 lv0", 12'h01C, 32'h0000_0100);
    rd("R4 R2 ev1", 12'h020, 32'h0000_0008);
    rd("R4 R2 ev0", 12'h010, 32'h0000_0100);
    cleanup();
  endtask

  task automatic t_edge();
    set_in(64'h20);                    // input 5 -> bank1 bit5
    set_in(64'h0);
    rd("R6 held ev1", 12'h020, 32'h20);
    wr(12'h028, 32'h1);                // clear another bit only
    rd("R8 unrelated clear", 12'h020, 32'h20);
    wr(12'h028, 32'h20);
    rd("R8 cleared", 12'h020, 32'h0);
    cleanup();
  endtask

  task automatic t_level();
    set_in(64'h0010_0000_3010_0000);   // inputs 20,28,29 and 52
    rd("R7 R13 ev1", 12'h020, 32'h2000_0000);
    rd("R13 ev0", 12'h010, 32'h0010_0000);
    rd("R7 lv1", 12'h02C, 32'h3010_0000);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h028, 32'h2000_0000);
    set_in(64'h0000_0000_0010_0000);   // only the level input 20
    chk("R10 masked off", {31'd0, irq_out}, 32'd0);
    wr(12'h024, 32'h0010_0000);
    chk("R10 level request", {31'd0, irq_out}, 32'd1);
    wr(12'h028, 32'h0010_0000);
    chk("R7 clear keeps level", {31'd0, irq_out}, 32'd1);
    set_in('0);
    chk("R10 level drop", {31'd0, irq_out}, 32'd0);
    cleanup();
  endtask

  task automatic t_mask();
    set_in(64'h1_0000_0000);           // input 32 -> bank0 bit0
    chk("R10 no mask", {31'd0, irq_out}, 32'd0);
    wr(12'h014, 32'h1);
    chk("R10 mask on", {31'd0, irq_out}, 32'd1);
    wr(12'h014, 32'h2);
    chk("R11 replaced", {31'd0, irq_out}, 32'd0);
    rd("R11 mask0", 12'h014, 32'h2);
    cleanup();
  endtask

  task automatic t_priority();
    set_in(64'h80);                    // input 7 -> bank1 bit7
    set_in(64'h0);
    irq_in    = 64'h80;
    reg_addr  = 12'h028;
    reg_wdata = 32'h80;
    reg_wen   = 1'b1;
    tick();
    reg_wen   = 1'b0;
    rd("R9 edge beats clear", 12'h020, 32'h80);
    cleanup();
  endtask

  task automatic t_decode();
    wr(12'h024, 32'hA5A5_0000);
    wr(12'h034, 32'hFFFF_FFFF);        // bank index 2
    wr(12'h004, 32'hFFFF_FFFF);        // below first bank
    wr(12'h015, 32'hFFFF_FFFF);        // unaligned offset
    rd("R3 idx2 read", 12'h034, 32'h0);
    rd("R3 low read", 12'h004, 32'h0);
    rd("R3 odd offset read", 12'h025, 32'h0);
    rd("R3 clear reads zero", 12'h028, 32'h0);
    rd("R3 mask0 untouched", 12'h014, 32'h0);
    rd("R2 mask1", 12'h024, 32'hA5A5_0000);
    set_in(64'h0000_0004_0000_0000);   // input 34 -> bank0 bit2
    set_in(64'h0);
    wr(12'h010, 32'h0);                // events is read-only
    rd("R3 events write ignored", 12'h010, 32'h4);
    cleanup();
  endtask

  initial begin
    rst_n     = 1'b0;
    reg_addr  = '0;
    reg_wen   = 1'b0;
    reg_wdata = '0;
    reg_ren   = 1'b0;
    irq_in    = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mapping();
    t_edge();
    t_level();
    t_mask();
    t_priority();
    t_decode();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule